// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register

This block holds the five live fields of a 10/100 PHY's basic control register: low-power mode, MII isolation, negotiation restart, forced duplex and collision self-test. A management front end that has already decoded the register address writes it through a write strobe and data word and reads it back combinationally. When reset is asserted, the block samples a set of strap pins and loads the isolation and duplex defaults from them.

The fields act directly on the pins around the media-independent interface. Isolation, which low-power mode also causes, drops the transmit inputs before they reach the PHY core and removes the drive from every MII output. Low-power mode also disables the copper line driver, the LED drivers and the fiber transmitter. The restart field sends a one-cycle start pulse to an external negotiation engine and holds until that engine reports completion. The collision self-test field makes COL follow transmit enable.

Top module: `phy_ctrl_reg`

## Requirements
- R1: While rst_n is low (synchronous, active low), the isolate field (bit 10) loads 1 when strap_phy_addr is all zeros and loads 0 for any other address.
- R2: While rst_n is low, the duplex field (bit 8) loads 0 if strap_repeater is 1. Otherwise it loads 1 exactly when strap_an_en is 0 and at least one of strap_fd100 or strap_fd10 is 1.
- R3: A write takes effect at the clock edge that samples reg_wr_en. reg_rdata shows the current fields with no delay. Bits 15:12 and 6:0 always read 0 and ignore writes.
- R4: Writing 1 to bit 11 enters low-power mode. Writing 0 to that bit has no effect, and only reset clears it.
- R5: While the isolate bit or the low-power bit is set, mii_out_oe is 0 and core_txd, core_tx_en and core_tx_er are 0. Otherwise mii_out_oe is 1 and the transmit inputs pass through unchanged.
- R6: While the low-power bit is set, line_tx_oe, led_oe and fiber_tx_en are 0. Otherwise all three are 1.
- R7: Writing 1 to bit 9 while an_enabled is 1 and the bit is 0 sets the bit and raises an_start for exactly one cycle, in the same cycle the bit rises. The bit stays set until a clock edge that samples an_done high, and it reads 0 after that edge.
- R8: Writing 1 to bit 9 while an_enabled is 0 has no effect: the bit stays 0 and an_start is not raised.
- R9: link_full_duplex equals the duplex bit (1 means full, 0 means half) while an_enabled is 0, and equals an_fd_result while an_enabled is 1.
- R10: While not isolated, mii_col_o is core_col OR (collision-test bit 7 AND mii_tx_en). While isolated, it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management and MII control clock |
| rst_n | input | 1 | Synchronous hardware reset, active low; straps sampled while low |
| strap_phy_addr | input | ADDR_W | Strapped PHY address |
| strap_repeater | input | 1 | Strap: repeater operation |
| strap_an_en | input | 1 | Strap: autonegotiation enabled |
| strap_fd100 | input | 1 | Strap: 100 Mb/s full duplex allowed |
| strap_fd10 | input | 1 | Strap: 10 Mb/s full duplex allowed |
| reg_wr_en | input | 1 | Write strobe for this register |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data, combinational |
| an_enabled | input | 1 | Autonegotiation currently enabled |
| an_done | input | 1 | Negotiation engine reports completion |
| an_fd_result | input | 1 | Negotiated duplex (1 full) |
| an_start | output | 1 | One-cycle start pulse to negotiation engine |
| link_full_duplex | output | 1 | Effective link duplex |
| mii_txd | input | MII_D_W | MII transmit data from MAC |
| mii_tx_en | input | 1 | MII transmit enable from MAC |
| mii_tx_er | input | 1 | MII transmit error from MAC |
| core_txd | output | MII_D_W | Gated transmit data to PHY core |
| core_tx_en | output | 1 | Gated transmit enable to PHY core |
| core_tx_er | output | 1 | Gated transmit error to PHY core |
| core_col | input | 1 | Collision detected by PHY core |
| mii_col_o | output | 1 | COL value toward MAC |
| mii_out_oe | output | 1 | Drive enable for all MII outputs (clocks, receive, COL, CRS) |
| line_tx_oe | output | 1 | Twisted-pair transmit driver enable |
| led_oe | output | 1 | LED output drive enable |
| fiber_tx_en | output | 1 | Fiber transmitter enable |

## Verification
The strap defaults are tried across several combinations: a zero and a nonzero address, repeater strapped against not strapped, and autonegotiation strapped on against off, with each full-duplex strap tried alone. These combinations separate the address test from the duplex equation and show that repeater takes precedence. Transmit traffic and core collisions run with the block open, isolated and in low power, which separates what the isolate bit gates from what low-power mode gates. Restart writes are made with negotiation disabled, then enabled, then repeated while a restart is pending, and completion arrives later. This separates the write condition from the pulse and from the self-clear. All-ones writes and a write of zero to the low-power bit show that the reserved bits and the reset-only clear hold.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;
  localparam int REG_W     = 16;
  localparam int PD_BIT    = 11;
  localparam int ISO_BIT   = 10;
  localparam int RAN_BIT   = 9;
  localparam int DPX_BIT   = 8;
  localparam int COLT_BIT  = 7;

  typedef struct packed {
    logic pd;
    logic iso;
    logic ran;
    logic dpx;
    logic colt;
  } ctrl_fields_t;
endpackage

// File: rtl/ctrl_strap_dflt.sv
module ctrl_strap_dflt #(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] strap_phy_addr,
  input  logic              strap_repeater,
  input  logic              strap_an_en,
  input  logic              strap_fd100,
  input  logic              strap_fd10,
  output logic              iso_dflt,
  output logic              dpx_dflt
);
  localparam logic [ADDR_W-1:0] ISO_ADDR = '0;

  always_comb begin
    iso_dflt = (strap_phy_addr == ISO_ADDR);
    if (strap_repeater)
      dpx_dflt = 1'b0;
    else
      dpx_dflt = !strap_an_en && (strap_fd100 || strap_fd10);
  end
endmodule

// File: rtl/ctrl_field_regs.sv
module ctrl_field_regs
  import phy_ctrl_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iso_dflt,
  input  logic              dpx_dflt,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              an_enabled,
  input  logic              an_done,
  output ctrl_fields_t      fields,
  output logic              an_start
);
  ctrl_fields_t f_q;
  logic         start_q;
  logic         ran_set;

  assign ran_set = wr_en && wdata[RAN_BIT] && an_enabled && !f_q.ran;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_q.pd   <= 1'b0;
      f_q.iso  <= iso_dflt;
      f_q.ran  <= 1'b0;
      f_q.dpx  <= dpx_dflt;
      f_q.colt <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      start_q <= ran_set;
      if (wr_en) begin
        if (wdata[PD_BIT]) f_q.pd <= 1'b1;
        f_q.iso  <= wdata[ISO_BIT];
        f_q.dpx  <= wdata[DPX_BIT];
        f_q.colt <= wdata[COLT_BIT];
      end
      if (ran_set)
        f_q.ran <= 1'b1;
      else if (f_q.ran && an_done)
        f_q.ran <= 1'b0;
    end
  end

  assign fields   = f_q;
  assign an_start = start_q;
endmodule

// File: rtl/ctrl_mii_gate.sv
module ctrl_mii_gate
  import phy_ctrl_pkg::*;
#(
  parameter int MII_D_W = 4
) (
  input  ctrl_fields_t       fields,
  input  logic [MII_D_W-1:0] mii_txd,
  input  logic               mii_tx_en,
  input  logic               mii_tx_er,
  input  logic               core_col,
  output logic [MII_D_W-1:0] core_txd,
  output logic               core_tx_en,
  output logic               core_tx_er,
  output logic               mii_col_o,
  output logic               mii_out_oe,
  output logic               line_tx_oe,
  output logic               led_oe,
  output logic               fiber_tx_en
);
  logic isolated;
  assign isolated = fields.iso || fields.pd;

  always_comb begin
    if (isolated) begin
      core_txd   = '0;
      core_tx_en = 1'b0;
      core_tx_er = 1'b0;
      mii_col_o  = 1'b0;
    end else begin
      core_txd   = mii_txd;
      core_tx_en = mii_tx_en;
      core_tx_er = mii_tx_er;
      mii_col_o  = core_col || (fields.colt && mii_tx_en);
    end
    mii_out_oe  = !isolated;
    line_tx_oe  = !fields.pd;
    led_oe      = !fields.pd;
    fiber_tx_en = !fields.pd;
  end
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
  import phy_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int MII_D_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  strap_phy_addr,
  input  logic               strap_repeater,
  input  logic               strap_an_en,
  input  logic               strap_fd100,
  input  logic               strap_fd10,
  input  logic               reg_wr_en,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               an_enabled,
  input  logic               an_done,
  input  logic               an_fd_result,
  output logic               an_start,
  output logic               link_full_duplex,
  input  logic [MII_D_W-1:0] mii_txd,
  input  logic               mii_tx_en,
  input  logic               mii_tx_er,
  output logic [MII_D_W-1:0] core_txd,
  output logic               core_tx_en,
  output logic               core_tx_er,
  input  logic               core_col,
  output logic               mii_col_o,
  output logic               mii_out_oe,
  output logic               line_tx_oe,
  output logic               led_oe,
  output logic               fiber_tx_en
);
  logic         iso_dflt;
  logic         dpx_dflt;
  ctrl_fields_t fields;

  ctrl_strap_dflt #(.ADDR_W(ADDR_W)) u_dflt (
    .strap_phy_addr (strap_phy_addr),
    .strap_repeater (strap_repeater),
    .strap_an_en    (strap_an_en),
    .strap_fd100    (strap_fd100),
    .strap_fd10     (strap_fd10),
    .iso_dflt       (iso_dflt),
    .dpx_dflt       (dpx_dflt)
  );

  ctrl_field_regs #(.DATA_W(REG_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .iso_dflt   (iso_dflt),
    .dpx_dflt   (dpx_dflt),
    .wr_en      (reg_wr_en),
    .wdata      (reg_wdata),
    .an_enabled (an_enabled),
    .an_done    (an_done),
    .fields     (fields),
    .an_start   (an_start)
  );

  ctrl_mii_gate #(.MII_D_W(MII_D_W)) u_gate (
    .fields      (fields),
    .mii_txd     (mii_txd),
    .mii_tx_en   (mii_tx_en),
    .mii_tx_er   (mii_tx_er),
    .core_col    (core_col),
    .core_txd    (core_txd),
    .core_tx_en  (core_tx_en),
    .core_tx_er  (core_tx_er),
    .mii_col_o   (mii_col_o),
    .mii_out_oe  (mii_out_oe),
    .line_tx_oe  (line_tx_oe),
    .led_oe      (led_oe),
    .fiber_tx_en (fiber_tx_en)
  );

  always_comb begin
    reg_rdata           = '0;
    reg_rdata[PD_BIT]   = fields.pd;
    reg_rdata[ISO_BIT]  = fields.iso;
    reg_rdata[RAN_BIT]  = fields.ran;
    reg_rdata[DPX_BIT]  = fields.dpx;
    reg_rdata[COLT_BIT] = fields.colt;
  end

  assign link_full_duplex = an_enabled ? an_fd_result : fields.dpx;
endmodule

// File: rtl/phy_ctrl_reg_chk.sv
module phy_ctrl_reg_chk
  import phy_ctrl_pkg::*;
#(
  parameter int MII_D_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr_en,
  input logic [REG_W-1:0]   reg_wdata,
  input logic [REG_W-1:0]   reg_rdata,
  input logic               an_enabled,
  input logic               an_done,
  input logic               an_start,
  input logic               link_full_duplex,
  input logic               mii_tx_en,
  input logic [MII_D_W-1:0] core_txd,
  input logic               core_tx_en,
  input logic               core_tx_er,
  input logic               mii_col_o,
  input logic               mii_out_oe,
  input logic               line_tx_oe,
  input logic               led_oe,
  input logic               fiber_tx_en
);
  logic isolated;
  assign isolated = reg_rdata[PD_BIT] || reg_rdata[ISO_BIT];

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[6:0] == '0 && reg_rdata[REG_W-1:12] == '0);

  assert_pd_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[PD_BIT] |=> reg_rdata[PD_BIT]);

  assert_isolate_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    isolated |-> (!mii_out_oe && !core_tx_en && !core_tx_er && core_txd == '0));

  assert_pd_drivers_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[PD_BIT] |-> (!line_tx_oe && !led_oe && !fiber_tx_en));

  assert_start_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    an_start |=> !an_start);

  assert_start_with_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    an_start |-> reg_rdata[RAN_BIT]);

  assert_restart_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[RAN_BIT] && !an_done) |=> reg_rdata[RAN_BIT]);

  assert_restart_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wdata[RAN_BIT] && !an_enabled && !reg_rdata[RAN_BIT])
      |=> (!reg_rdata[RAN_BIT] && !an_start));

  assert_forced_duplex_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !an_enabled |-> (link_full_duplex == reg_rdata[DPX_BIT]));

  assert_col_test_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!isolated && reg_rdata[COLT_BIT] && mii_tx_en) |-> mii_col_o);
endmodule

bind phy_ctrl_reg phy_ctrl_reg_chk #(.MII_D_W(MII_D_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .reg_wr_en        (reg_wr_en),
  .reg_wdata        (reg_wdata),
  .reg_rdata        (reg_rdata),
  .an_enabled       (an_enabled),
  .an_done          (an_done),
  .an_start         (an_start),
  .link_full_duplex (link_full_duplex),
  .mii_tx_en        (mii_tx_en),
  .core_txd         (core_txd),
  .core_tx_en       (core_tx_en),
  .core_tx_er       (core_tx_er),
  .mii_col_o        (mii_col_o),
  .mii_out_oe       (mii_out_oe),
  .line_tx_oe       (line_tx_oe),
  .led_oe           (led_oe),
  .fiber_tx_en      (fiber_tx_en)
);

// File: tb/phy_ctrl_reg_test.sv
module phy_ctrl_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  strap_phy_addr = '0;
  logic        strap_repeater = 1'b0, strap_an_en = 1'b0, strap_fd100 = 1'b0, strap_fd10 = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        an_enabled = 1'b0, an_done = 1'b0, an_fd_result = 1'b0;
  logic        an_start, link_full_duplex;
  logic [3:0]  mii_txd = '0;
  logic        mii_tx_en = 1'b0, mii_tx_er = 1'b0;
  logic [3:0]  core_txd;
  logic        core_tx_en, core_tx_er;
  logic        core_col = 1'b0;
  logic        mii_col_o, mii_out_oe, line_tx_oe, led_oe, fiber_tx_en;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;
  bit finished = 1'b0;

  // behavioural reference state
  bit m_pd, m_iso, m_ran, m_dpx, m_colt, m_start;

  always #2 clk = ~clk;

  phy_ctrl_reg uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model update at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pd = 0; m_ran = 0; m_colt = 0; m_start = 0;
      m_iso = (strap_phy_addr == 5'd0);
      m_dpx = strap_repeater ? 1'b0 : (!strap_an_en && (strap_fd100 || strap_fd10));
    end else begin
      bit do_set;
      do_set = reg_wr_en && reg_wdata[9] && an_enabled && !m_ran;
      m_start = do_set;
      if (reg_wr_en) begin
        if (reg_wdata[11]) m_pd = 1;
        m_iso = reg_wdata[10];
        m_dpx = reg_wdata[8];
        m_colt = reg_wdata[7];
      end
      if (do_set) m_ran = 1;
      else if (m_ran && an_done) m_ran = 0;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      bit iso_eff;
      iso_eff = m_iso || m_pd;
      chk("R3 rdata", reg_rdata, {4'b0, m_pd, m_iso, m_ran, m_dpx, m_colt, 7'b0});
      chk("R7 an_start", an_start, m_start);
      chk("R5 mii_out_oe", mii_out_oe, !iso_eff);
      chk("R5 core_tx", {core_txd, core_tx_en, core_tx_er},
          iso_eff ? 6'b0 : {mii_txd, mii_tx_en, mii_tx_er});
      chk("R6 drivers", {line_tx_oe, led_oe, fiber_tx_en}, m_pd ? 3'b000 : 3'b111);
      chk("R10 col", mii_col_o, iso_eff ? 1'b0 : (core_col || (m_colt && mii_tx_en)));
      chk("R9 duplex", link_full_duplex, an_enabled ? an_fd_result : m_dpx);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [15:0] d);
    reg_wr_en = 1; reg_wdata = d;
    tick(1);
    reg_wr_en = 0; reg_wdata = '0;
  endtask

  task automatic do_reset(input logic [4:0] a, input bit rep, input bit ane, input bit f100, input bit f10);
    strap_phy_addr = a; strap_repeater = rep; strap_an_en = ane;
    strap_fd100 = f100; strap_fd10 = f10;
    rst_n = 0;
    tick(2);
    rst_n = 1;
    tick(1);
  endtask

  initial begin : stim
    tick(1);
    rst_n = 0;
    @(posedge clk); #1;
    cmp_on = 1;
    // R1/R2 strap combinations
    do_reset(5'd0, 0, 0, 1, 0);
    chk("R1 iso from zero addr", reg_rdata[10], 1'b1);
    chk("R2 dpx fd100", reg_rdata[8], 1'b1);
    mii_txd = 4'hA; mii_tx_en = 1; mii_tx_er = 1; core_col = 1;
    tick(2);
    mii_tx_en = 0; mii_tx_er = 0; core_col = 0;
    do_reset(5'd5, 1, 0, 1, 1);
    chk("R1 iso nonzero addr", reg_rdata[10], 1'b0);
    chk("R2 repeater forces half", reg_rdata[8], 1'b0);
    do_reset(5'd3, 0, 1, 1, 1);
    chk("R2 an strap forces half", reg_rdata[8], 1'b0);
    do_reset(5'd3, 0, 0, 0, 0);
    chk("R2 no fd strap", reg_rdata[8], 1'b0);
    do_reset(5'd3, 0, 0, 0, 1);
    chk("R2 dpx fd10", reg_rdata[8], 1'b1);
    // R5 open path traffic
    for (int i = 0; i < 6; i++) begin
      mii_txd = 4'(i * 3); mii_tx_en = i[0]; mii_tx_er = i[1];
      tick(1);
    end
    // R10 collision test
    wr(16'h0080);
    for (int i = 0; i < 4; i++) begin
      mii_tx_en = i[0]; core_col = i[1];
      tick(1);
    end
    mii_tx_en = 1;
    tick(1);
    chk("R10 col follows txen", mii_col_o, 1'b1);
    mii_tx_en = 0; core_col = 0;
    // R9 duplex source
    wr(16'h0100);
    an_fd_result = 0; tick(1);
    chk("R9 forced full", link_full_duplex, 1'b1);
    an_enabled = 1; tick(1);
    chk("R9 negotiated half", link_full_duplex, 1'b0);
    an_fd_result = 1; tick(1);
    // R8 restart while negotiation disabled
    an_enabled = 0;
    wr(16'h0200);
    chk("R8 restart ignored", {reg_rdata[9], an_start}, 2'b00);
    // R7 restart while enabled
    an_enabled = 1;
    reg_wr_en = 1; reg_wdata = 16'h0200;
    tick(1);
    reg_wr_en = 0; reg_wdata = '0;
    chk("R7 bit set", reg_rdata[9], 1'b1);
    chk("R7 pulse", an_start, 1'b1);
    tick(1);
    chk("R7 pulse single", an_start, 1'b0);
    wr(16'h0200);
    chk("R7 no repeat pulse", an_start, 1'b0);
    tick(3);
    chk("R7 holds until done", reg_rdata[9], 1'b1);
    an_done = 1; tick(1); an_done = 0;
    chk("R7 cleared on done", reg_rdata[9], 1'b0);
    tick(1);
    // R3 reserved bits and immediate effect
    an_enabled = 0;
    wr(16'hF07F);
    chk("R3 reserved read zero", reg_rdata, 16'h0000);
    // R5 isolate only
    wr(16'h0480);
    mii_txd = 4'hF; mii_tx_en = 1; mii_tx_er = 1;
    tick(2);
    chk("R5 isolated oe", mii_out_oe, 1'b0);
    chk("R6 iso keeps drivers", line_tx_oe, 1'b1);
    wr(16'h0000);
    // R4 powerdown set, write 0, reset clear
    wr(16'h0800);
    tick(2);
    chk("R6 pd drivers off", {line_tx_oe, led_oe, fiber_tx_en}, 3'b000);
    wr(16'h0000);
    chk("R4 pd survives write 0", reg_rdata[11], 1'b1);
    mii_tx_en = 0; mii_tx_er = 0;
    do_reset(5'd9, 0, 0, 0, 0);
    chk("R4 reset clears pd", reg_rdata[11], 1'b0);
    tick(3);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule